// File: doc/BRIEF.md
# Table-driven weighted round-robin queue scheduler

This block chooses which egress queue of one switch port is served next. The service order is a programmable table of queue numbers. The scheduler steps through the table slot by slot and wraps back to slot 0 after the last programmed slot. Each queue's weight is the number of slots that carry its number. A slot whose queue is currently empty is skipped within the same cycle: the scheduler searches forward, wrapping if needed, for the nearest slot whose queue has data. A downstream consumer sees `sel_valid` with a one-hot `sel_grant` and the binary `sel_queue`. It accepts the choice by raising `sel_ready` in the same cycle. Only an accepted choice moves the table pointer.

Software loads the table through a 16-bit write port, one group of consecutive slots per write. In the 4-queue build a write carries four 2-bit codes. In the 8-queue build it carries two 3-bit codes. The build is chosen with the `NUM_QUEUES` parameter. Bit 15 of a write is the go flag, and it reads back on `host_busy` while the entries are being committed. A separate length strobe sets how many slots are in use, up to `MAX_SLOTS`.

Back-pressure rules on the grant stream: the pointer advances only in a cycle where `sel_valid` and `sel_ready` are both high. While `sel_ready` is low, the choice is held as long as the table, the length and `q_nonempty` do not change. Because the queues live outside the block, `sel_valid` may fall without a handshake when the chosen queue drains.

Top module: `wrr_sched`

## Requirements
- R1: After reset in the 4-queue build, the table holds 15 slots with the codes 3,2,3,1,3,2,3,0,3,2,3,1,3,2,3. Queue 3 therefore gets the most service and queue 0 the least. In the 8-queue build, the table holds 8 slots with the codes 7,6,5,7,1,6,7,4. In both builds the pointer starts at slot 0.
- R2: When `sel_valid` is high, `sel_grant` has exactly bit n set, where n = `sel_queue`, and `q_nonempty[n]` is high. When `sel_valid` is low, `sel_grant` is all zeros.
- R3: The chosen slot is the first slot at or after the pointer whose queue is non-empty. The search wraps past the last programmed slot, and the result appears in the same cycle as the inputs.
- R4: If no programmed slot names a non-empty queue (including the case where all queues are empty), `sel_valid` is low and the pointer holds.
- R5: When `sel_valid` and `sel_ready` are both high at a clock edge, the pointer moves to the slot after the chosen one, or to slot 0 if the chosen slot is the last programmed slot. When `sel_ready` is low, the pointer does not move.
- R6: A table write uses bit 15 as the go flag and bits 14:8 as the group index g. In the 4-queue build, bits 1:0, 3:2, 5:4 and 7:6 go to slots 4g, 4g+1, 4g+2 and 4g+3. In the 8-queue build, bits 2:0 and 6:4 go to slots 2g and 2g+1.
- R7: A write with bit 15 set, made while `host_busy` is low, raises `host_busy` for exactly one cycle, and the new entries take effect when it clears. A write made while `host_busy` is high, or a write with bit 15 clear, changes neither the table nor `host_busy`.
- R8: A length strobe with a value from 1 to `MAX_SLOTS` (128 by default) sets the programmed length and returns the pointer to slot 0. A value of 0, or a value above `MAX_SLOTS`, is rejected and has no effect on either the length or the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Table write strobe |
| host_wdata | input | 16 | Table write word (go flag, group index, packed codes) |
| host_busy | output | 1 | Go flag read-back; high while a group is being committed |
| len_we | input | 1 | Length write strobe |
| len_val | input | clog2(MAX_SLOTS+1) | Requested number of programmed slots |
| q_nonempty | input | NUM_QUEUES | Per-queue "has data" flags |
| sel_ready | input | 1 | Consumer accepts the current choice |
| sel_valid | output | 1 | A choice is available |
| sel_grant | output | NUM_QUEUES | One-hot grant of the chosen queue |
| sel_queue | output | clog2(NUM_QUEUES) | Number of the chosen queue |

## Verification
The assertions assume that software waits for `host_busy` to clear before writing again. They also assume that the hold-while-stalled property applies only when `q_nonempty` stays stable, and only in cycles with no length strobe and no pending commit. The stimulus changes inputs only at falling edges. It waits out the busy cycle before every table write except one, which is made on purpose during the busy cycle to show that it is dropped. It changes `q_nonempty` only between accepted choices, or in a cycle where stalling is checked against an unchanged vector.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int HOST_W  = 16;
  localparam int GO_BIT  = 15;
  localparam int GRP_LSB = 8;
  localparam int GRP_W   = 7;

  // Power-up queue code for a slot.
  // 4-queue build: the code is 3 minus the trailing-zero count of slot+1.
  function automatic int unsigned wrr_reset_code(int unsigned slot, int unsigned nq);
    if (nq == 8) begin
      case (slot % 8)
        0: return 7; 1: return 6; 2: return 5; 3: return 7;
        4: return 1; 5: return 6; 6: return 7; default: return 4;
      endcase
    end
    if (((slot + 1) % 8) == 0) return 0;
    if (((slot + 1) % 4) == 0) return 1;
    if (((slot + 1) % 2) == 0) return 2;
    return 3;
  endfunction

  function automatic int unsigned wrr_reset_len(int unsigned nq);
    return (nq == 8) ? 8 : 15;
  endfunction
endpackage

// File: rtl/wrr_host_port.sv
module wrr_host_port #(
  parameter int NUM_QUEUES = 4,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam int EPW = (NUM_QUEUES == 8) ? 2 : 4,
  localparam int FSTRIDE = 8 / EPW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_we,
  input  logic [wrr_pkg::HOST_W-1:0]   host_wdata,
  output logic                         host_busy,
  output logic                         cm_en,
  output logic [wrr_pkg::GRP_W-1:0]    cm_group,
  output logic [EPW*QW-1:0]            cm_codes
);
  import wrr_pkg::*;

  logic              accept;
  logic [EPW*QW-1:0] codes_in;
  logic              unused_wdata;

  assign accept       = host_we && host_wdata[GO_BIT] && !host_busy;
  assign unused_wdata = ^host_wdata;

  for (genvar j = 0; j < EPW; j++) begin : g_unpack
    assign codes_in[j*QW +: QW] = host_wdata[j*FSTRIDE +: QW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_busy <= 1'b0;
      cm_group  <= '0;
      cm_codes  <= '0;
    end else begin
      host_busy <= accept;
      if (accept) begin
        cm_group <= host_wdata[GRP_LSB +: GRP_W];
        cm_codes <= codes_in;
      end
    end
  end

  assign cm_en = host_busy;
endmodule

// File: rtl/wrr_slot_table.sv
module wrr_slot_table #(
  parameter int NUM_QUEUES = 4,
  parameter int MAX_SLOTS = 128,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam int EPW = (NUM_QUEUES == 8) ? 2 : 4,
  localparam int LEN_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cm_en,
  input  logic [wrr_pkg::GRP_W-1:0] cm_group,
  input  logic [EPW*QW-1:0]         cm_codes,
  input  logic                      len_we,
  input  logic [LEN_W-1:0]          len_val,
  output logic [MAX_SLOTS*QW-1:0]   tbl_flat,
  output logic [LEN_W-1:0]          cur_len,
  output logic                      len_load
);
  import wrr_pkg::*;

  assign len_load = len_we && (len_val != '0) && (int'(len_val) <= MAX_SLOTS);

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    localparam int GS = s / EPW;
    localparam int JS = s % EPW;
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl_flat[s*QW +: QW] <= QW'(wrr_reset_code(s, NUM_QUEUES));
      else if (cm_en && (cm_group == GRP_W'(GS)))
        tbl_flat[s*QW +: QW] <= cm_codes[JS*QW +: QW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cur_len <= LEN_W'(wrr_reset_len(NUM_QUEUES));
    else if (len_load) cur_len <= len_val;
  end
endmodule

// File: rtl/wrr_slot_search.sv
module wrr_slot_search #(
  parameter int NUM_QUEUES = 4,
  parameter int MAX_SLOTS = 128,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int LEN_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic [MAX_SLOTS*QW-1:0] tbl_flat,
  input  logic [LEN_W-1:0]        cur_len,
  input  logic [SLOT_W-1:0]       ptr,
  input  logic [NUM_QUEUES-1:0]   q_nonempty,
  output logic                    hit,
  output logic [SLOT_W-1:0]       hit_slot,
  output logic [QW-1:0]           hit_code
);
  always_comb begin
    int unsigned idx;
    logic [QW-1:0] code;
    hit      = 1'b0;
    hit_slot = '0;
    hit_code = '0;
    for (int k = 0; k < MAX_SLOTS; k++) begin
      idx = int'(ptr) + k;
      if (idx >= int'(cur_len)) idx = idx - int'(cur_len);
      code = tbl_flat[idx*QW +: QW];
      if (!hit && (k < int'(cur_len)) && q_nonempty[code]) begin
        hit      = 1'b1;
        hit_slot = SLOT_W'(idx);
        hit_code = code;
      end
    end
  end
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched #(
  parameter int NUM_QUEUES = 4,
  parameter int MAX_SLOTS = 128,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam int EPW = (NUM_QUEUES == 8) ? 2 : 4,
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int LEN_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [15:0]           host_wdata,
  output logic                  host_busy,
  input  logic                  len_we,
  input  logic [LEN_W-1:0]      len_val,
  input  logic [NUM_QUEUES-1:0] q_nonempty,
  input  logic                  sel_ready,
  output logic                  sel_valid,
  output logic [NUM_QUEUES-1:0] sel_grant,
  output logic [QW-1:0]         sel_queue
);
  import wrr_pkg::*;

  logic                    cm_en;
  logic [GRP_W-1:0]        cm_group;
  logic [EPW*QW-1:0]       cm_codes;
  logic [MAX_SLOTS*QW-1:0] tbl_flat;
  logic [LEN_W-1:0]        cur_len;
  logic                    len_load;
  logic [SLOT_W-1:0]       ptr;
  logic                    hit;
  logic [SLOT_W-1:0]       hit_slot;
  logic [QW-1:0]           hit_code;
  logic [LEN_W-1:0]        nxt;

  wrr_host_port #(.NUM_QUEUES(NUM_QUEUES)) u_host (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_busy(host_busy), .cm_en(cm_en), .cm_group(cm_group), .cm_codes(cm_codes)
  );

  wrr_slot_table #(.NUM_QUEUES(NUM_QUEUES), .MAX_SLOTS(MAX_SLOTS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .cm_en(cm_en), .cm_group(cm_group), .cm_codes(cm_codes),
    .len_we(len_we), .len_val(len_val), .tbl_flat(tbl_flat), .cur_len(cur_len),
    .len_load(len_load)
  );

  wrr_slot_search #(.NUM_QUEUES(NUM_QUEUES), .MAX_SLOTS(MAX_SLOTS)) u_search (
    .tbl_flat(tbl_flat), .cur_len(cur_len), .ptr(ptr), .q_nonempty(q_nonempty),
    .hit(hit), .hit_slot(hit_slot), .hit_code(hit_code)
  );

  assign nxt = LEN_W'(hit_slot) + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr <= '0;
    else if (len_load)          ptr <= '0;
    else if (hit && sel_ready)  ptr <= (nxt == cur_len) ? '0 : SLOT_W'(nxt);
  end

  assign sel_valid = hit;
  assign sel_queue = hit_code;
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_grant
    assign sel_grant[q] = hit && (hit_code == QW'(q));
  end
endmodule

// File: rtl/wrr_sched_chk.sv
module wrr_sched_chk #(
  parameter int NUM_QUEUES = 4,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_we,
  input logic [15:0]           host_wdata,
  input logic                  host_busy,
  input logic                  len_we,
  input logic [NUM_QUEUES-1:0] q_nonempty,
  input logic                  sel_ready,
  input logic                  sel_valid,
  input logic [NUM_QUEUES-1:0] sel_grant,
  input logic [QW-1:0]         sel_queue
);
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_grant) && (sel_valid == (sel_grant != '0)));

  a_r2_granted_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> q_nonempty[sel_queue]);

  a_r4_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (q_nonempty == '0) |-> (!sel_valid && sel_grant == '0));

  a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready && !len_we && !host_busy) |=>
      ($stable(q_nonempty) |-> (sel_valid && sel_queue == $past(sel_queue))));

  a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |=> !host_busy);

  a_r7_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_wdata[15] && !host_busy) |=> host_busy);

  a_r7_no_go_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy && !(host_we && host_wdata[15])) |=> !host_busy);
endmodule

bind wrr_sched wrr_sched_chk #(.NUM_QUEUES(NUM_QUEUES)) u_chk (.*);

// File: tb/tb_wrr_sched.sv
`timescale 1ns/1ps
module tb_wrr_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // 4-queue instance
  logic        host_we = 0;
  logic [15:0] host_wdata = '0;
  logic        host_busy;
  logic        len_we = 0;
  logic [7:0]  len_val = '0;
  logic [3:0]  ne4 = '0;
  logic        rdy4 = 0;
  logic        v4;
  logic [3:0]  g4;
  logic [1:0]  q4;

  // 8-queue instance
  logic        h8_we = 0;
  logic [15:0] h8_data = '0;
  logic        h8_busy;
  logic        l8_we = 0;
  logic [7:0]  l8_val = '0;
  logic [7:0]  ne8 = '0;
  logic        rdy8 = 0;
  logic        v8;
  logic [7:0]  g8;
  logic [2:0]  q8;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wrr_sched #(.NUM_QUEUES(4)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_busy(host_busy), .len_we(len_we), .len_val(len_val), .q_nonempty(ne4),
    .sel_ready(rdy4), .sel_valid(v4), .sel_grant(g4), .sel_queue(q4)
  );

  wrr_sched #(.NUM_QUEUES(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .host_we(h8_we), .host_wdata(h8_data),
    .host_busy(h8_busy), .len_we(l8_we), .len_val(l8_val), .q_nonempty(ne8),
    .sel_ready(rdy8), .sel_valid(v8), .sel_grant(g8), .sel_queue(q8)
  );

  // {ready, nonempty[3:0], expected valid, expected queue[1:0]} on the reset table
  localparam logic [7:0] VEC [18] = '{
    8'b1_1111_1_11, 8'b1_1111_1_10, 8'b1_1111_1_11, 8'b1_1111_1_01,
    8'b1_0001_1_00, 8'b1_0110_1_10, 8'b1_0010_1_01, 8'b1_0000_0_00,
    8'b1_0001_1_00, 8'b1_1000_1_11, 8'b1_0100_1_10, 8'b1_1111_1_11,
    8'b0_1111_1_01, 8'b1_1111_1_01, 8'b1_1111_1_11, 8'b1_0100_1_10,
    8'b1_1000_1_11, 8'b1_1111_1_11
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step4(input logic [3:0] ne, input logic rdy, input logic ev,
                       input logic [1:0] eq, input string req);
    @(negedge clk);
    ne4 = ne; rdy4 = rdy;
    #1;
    chk({req, " valid"}, v4, ev);
    if (ev) begin
      chk({req, " queue"}, q4, eq);
      chk({req, " grant"}, g4, 1 << eq);
    end else chk({req, " grant idle"}, g4, 0);
    @(posedge clk); #1 rdy4 = 0;
  endtask

  task automatic step8(input logic [7:0] ne, input logic [2:0] eq, input string req);
    @(negedge clk);
    ne8 = ne; rdy8 = 1;
    #1;
    chk({req, " valid8"}, v8, 1);
    chk({req, " queue8"}, q8, eq);
    chk({req, " grant8"}, g8, 1 << eq);
    @(posedge clk); #1 rdy8 = 0;
  endtask

  task automatic wr4(input logic [15:0] d);
    @(negedge clk); host_we = 1; host_wdata = d;
    @(negedge clk); host_we = 0;
    @(negedge clk);
  endtask

  task automatic len4(input logic [7:0] v);
    @(negedge clk); len_we = 1; len_val = v;
    @(negedge clk); len_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // Reset state
    #1;
    chk("R7 busy after reset", host_busy, 0);
    chk("R4 no grant when all empty", v4, 0);
    step4(4'b1111, 1'b0, 1'b1, 2'd3, "R1 reset slot0 code");

    // Vector walk over the reset table (R1 R3 R4 R5)
    foreach (VEC[i]) begin
      step4(VEC[i][6:3], VEC[i][7], VEC[i][2], VEC[i][1:0], $sformatf("R3 R4 R5 vec%0d", i));
    end
    // pointer is now at slot 1

    // R6/R7: group 0 gets codes 0,1,2,3; a second write during busy is dropped
    @(negedge clk); host_we = 1; host_wdata = 16'h80E4;
    @(negedge clk);
    chk("R7 busy after go write", host_busy, 1);
    host_wdata = 16'h80AA;
    @(negedge clk);
    chk("R7 busy clears after one cycle", host_busy, 0);
    host_we = 0;
    len4(8'd4);
    step4(4'b1111, 1, 1, 2'd0, "R6 slot0 field 1:0");
    step4(4'b1111, 1, 1, 2'd1, "R6 slot1 field 3:2");
    step4(4'b1111, 1, 1, 2'd2, "R6 R7 slot2 field 5:4 not overwritten");
    step4(4'b1111, 1, 1, 2'd3, "R6 slot3 field 7:6");
    step4(4'b1111, 1, 1, 2'd0, "R5 R8 wrap after length 4");

    // R8: rejected lengths leave pointer and length untouched
    len4(8'd129);
    step4(4'b1111, 1, 1, 2'd1, "R8 length 129 rejected");
    len4(8'd0);
    step4(4'b1111, 1, 1, 2'd2, "R8 length 0 rejected");
    step4(4'b1111, 1, 1, 2'd3, "R8 length kept");
    step4(4'b1111, 1, 1, 2'd0, "R8 wrap kept at 4");

    // R7: write without go flag is ignored
    @(negedge clk); host_we = 1; host_wdata = 16'h00FF;
    @(negedge clk); host_we = 0;
    chk("R7 no busy without go", host_busy, 0);
    @(negedge clk);
    step4(4'b1111, 1, 1, 2'd1, "R7 table unchanged slot1");
    step4(4'b1111, 1, 1, 2'd2, "R7 table unchanged slot2");

    // R6: group 1 fills slots 4..7 with code 3, then length 8
    wr4(16'h81FF);
    len4(8'd8);
    step4(4'b0001, 1, 1, 2'd0, "R6 R8 slot0 after length 8");
    step4(4'b1000, 1, 1, 2'd3, "R3 skip to slot3");
    step4(4'b1000, 1, 1, 2'd3, "R6 group1 slot4");
    step4(4'b0001, 1, 1, 2'd0, "R3 wrap search to slot0");

    // 8-queue build: reset sequence and wrap (R1)
    step8(8'hFF, 3'd7, "R1 8q s0");
    step8(8'hFF, 3'd6, "R1 8q s1");
    step8(8'hFF, 3'd5, "R1 8q s2");
    step8(8'hFF, 3'd7, "R1 8q s3");
    step8(8'hFF, 3'd1, "R1 8q s4");
    step8(8'hFF, 3'd6, "R1 8q s5");
    step8(8'hFF, 3'd7, "R1 8q s6");
    step8(8'hFF, 3'd4, "R1 8q s7");
    step8(8'hFF, 3'd7, "R1 R5 8q wrap");

    // 8-queue write format (R6): bits 2:0 -> slot0 = 2, bits 6:4 -> slot1 = 5
    @(negedge clk); h8_we = 1; h8_data = 16'h8052;
    @(negedge clk); h8_we = 0;
    chk("R7 8q busy", h8_busy, 1);
    @(negedge clk);
    chk("R7 8q busy clear", h8_busy, 0);
    l8_we = 1; l8_val = 8'd2;
    @(negedge clk); l8_we = 0;
    step8(8'hFF, 3'd2, "R6 8q slot0");
    step8(8'hFF, 3'd5, "R6 8q slot1");
    step8(8'hFF, 3'd2, "R6 8q wrap");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule